// File: doc/BRIEF.md
# Spiking Winner-Take-All Pattern Classifier

This block sorts a 5×5 black-and-white image into one of eight classes with a small two-layer spiking network. A strobe captures the 25-bit image and opens a presentation window. During the window, every black pixel (bit value 1) emits one spike on every clock cycle, and white pixels stay silent. Each of the eight output neurons gates those spikes through its own row of binary weights and feeds the result into a leaky integrate-and-fire membrane.

The output neurons compete through lateral inhibition. On any cycle where one or more membranes cross the threshold, only the lowest-index firing neuron emits a counted spike, and every membrane in the layer is cleared. Each neuron counts its emitted spikes over the window. When the window closes, the block reports the neuron with the highest count as the class and raises a one-cycle valid pulse. The weights are trained elsewhere and written in one row per neuron before or between presentations.

Top module: `spiking_wta_classifier`

## Requirements
- R1: After reset, `class_valid` is 0 and no window is running. All weight rows, membranes and spike counts are zero.
- R2: A `start` sampled high captures `pattern`, clears all membranes and counts, and runs exactly L membrane updates, where L is the value of `win_len`. `class_valid` is then high in the cycle that begins L+1 clock edges after the start edge.
- R3: A `win_len` of 0 selects the default window of 256 updates.
- R4: On each update, a neuron's drive is the number of pixel positions j where both `pattern[j]` and bit j of that neuron's weight row are 1. A nonzero drive adds 2×drive to the 10-bit membrane, saturating at 1023. A zero drive leaks the membrane to u − (u >> 3).
- R5: A neuron fires on an update when its new membrane value is at least 200.
- R6: If any neuron fires on an update, only the lowest-index firing neuron has its spike counted, and every membrane in the layer, including those of the other firing neurons, is set to 0.
- R7: Each 8-bit spike count saturates at 255 and does not wrap.
- R8: While `class_valid` is high, `class_id` is the index of the largest spike count, with ties resolved to the lowest index. `class_valid` stays high for exactly one cycle.
- R9: A cycle with `wr_en` high writes `wr_row` into the weight row of neuron `wr_idx`. Bit j of the row is the weight of pixel j, where j = 5×row + column, matching `pattern[j]`. A write made during a window applies from the next update onward.
- R10: A `start` during a running window discards that window, produces no valid pulse for it, and begins a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the image and opens a window |
| pattern | input | 25 | Binary image, bit 5×row+col |
| win_len | input | 16 | Window length in updates; 0 selects 256 |
| wr_en | input | 1 | Weight row write enable |
| wr_idx | input | 3 | Output neuron whose row is written |
| wr_row | input | 25 | Weight row data, one bit per pixel |
| class_id | output | 3 | Winning neuron index, meaningful with class_valid |
| class_valid | output | 1 | One-cycle pulse at the end of a window |

## Verification
The bench targets these cases:
- **Bit-position check:** a single pixel at the far corner is matched by a single weight bit. A design with a swapped bit order would report the wrong class. A window that closes before that neuron can fire must report class 0 through the all-zero tie; a design that resolved ties upward would report another class.
- **Leak check:** a weight row is cleared and then restored in the middle of a window. A membrane that holds its value instead of leaking would then fire early and change the reported class.
- **Saturation check:** a lone neuron fires exactly 512 times. A wrapping counter would return to zero and lose the class.
- **Window-length checks:** a zero window length must produce a 257-cycle latency. A restarted window must report only the second image.

// File: rtl/spiking_wta_classifier.sv
`timescale 1ns/1ps
module spiking_wta_classifier #(
  parameter int NPIX    = 25,
  parameter int NCLS    = 8,
  parameter int IDXW    = $clog2(NCLS),
  parameter int UW      = 10,
  parameter int THRESH  = 200,
  parameter int GAIN_SH = 1,
  parameter int LEAK_SH = 3,
  parameter int CW      = 8,
  parameter int WLW     = 16,
  parameter int DEF_WIN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NPIX-1:0] pattern,
  input  logic [WLW-1:0]  win_len,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [NPIX-1:0] wr_row,
  output logic [IDXW-1:0] class_id,
  output logic            class_valid
);
  localparam int DW = $clog2(NPIX + 1);

  logic [NPIX-1:0] wmem [NCLS];
  logic [NPIX-1:0] pat_q;
  logic [UW-1:0]   u    [NCLS];
  logic [UW-1:0]   nxt  [NCLS];
  logic [CW-1:0]   cnt  [NCLS];
  logic [NCLS-1:0] fire, win_oh;
  logic            any_fire, busy, fin, u_zero, cnt_zero;
  logic [WLW-1:0]  rem;
  logic [CW-1:0]   best_c;

  function automatic logic [DW-1:0] popc(input logic [NPIX-1:0] v);
    popc = '0;
    for (int k = 0; k < NPIX; k++) popc = popc + DW'(v[k]);
  endfunction

  for (genvar g = 0; g < NCLS; g++) begin : g_nrn
    logic [DW-1:0] drv;
    logic [UW:0]   sum;
    assign drv     = popc(pat_q & wmem[g]);
    assign sum     = {1'b0, u[g]} + ((UW+1)'(drv) << GAIN_SH);
    assign nxt[g]  = (drv == '0) ? u[g] - (u[g] >> LEAK_SH)
                                 : (sum[UW] ? '1 : sum[UW-1:0]);
    assign fire[g] = nxt[g] >= UW'(THRESH);

    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && cnt[g] == '1) |=> cnt[g] == '1);
  end

  assign any_fire = |fire;

  always_comb begin
    win_oh = '0;
    for (int k = NCLS - 1; k >= 0; k--)
      if (fire[k]) begin
        win_oh    = '0;
        win_oh[k] = 1'b1;
      end
  end

  always_comb begin
    class_id = '0;
    best_c   = cnt[0];
    for (int k = 1; k < NCLS; k++)
      if (cnt[k] > best_c) begin
        best_c   = cnt[k];
        class_id = IDXW'(k);
      end
  end

  always_comb begin
    u_zero   = 1'b1;
    cnt_zero = 1'b1;
    for (int k = 0; k < NCLS; k++) begin
      if (u[k] != '0)   u_zero   = 1'b0;
      if (cnt[k] != '0) cnt_zero = 1'b0;
    end
  end

  assign class_valid = fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCLS; k++) wmem[k] <= '0;
    end else if (wr_en) begin
      wmem[wr_idx] <= wr_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fin   <= 1'b0;
      rem   <= '0;
      pat_q <= '0;
      for (int k = 0; k < NCLS; k++) begin
        u[k]   <= '0;
        cnt[k] <= '0;
      end
    end else if (start) begin
      busy  <= 1'b1;
      fin   <= 1'b0;
      rem   <= (win_len == '0) ? WLW'(DEF_WIN) : win_len;
      pat_q <= pattern;
      for (int k = 0; k < NCLS; k++) begin
        u[k]   <= '0;
        cnt[k] <= '0;
      end
    end else if (busy) begin
      rem  <= rem - 1'b1;
      fin  <= (rem == WLW'(1));
      busy <= (rem != WLW'(1));
      for (int k = 0; k < NCLS; k++) begin
        u[k] <= any_fire ? '0 : nxt[k];
        if (win_oh[k] && cnt[k] != '1) cnt[k] <= cnt[k] + 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid |=> !class_valid);
  p_inhibit_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && any_fire) |=> u_zero);
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cnt_zero && u_zero && !class_valid));
  p_one_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && (any_fire == (win_oh != '0)));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(best_c));
endmodule

// File: tb/test_spiking_wta_classifier.sv
`timescale 1ns/1ps
module test_spiking_wta_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [24:0] pattern = '0;
  logic [15:0] win_len = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [24:0] wr_row = '0;
  logic [2:0]  class_id;
  logic        class_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [24:0] mw [8];
  int mu [8];
  int mc [8];

  always #4 clk = ~clk;

  spiking_wta_classifier i_spiking_wta_classifier (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
    .win_len(win_len), .wr_en(wr_en), .wr_idx(wr_idx), .wr_row(wr_row),
    .class_id(class_id), .class_valid(class_valid));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [24:0] v);
    int c = 0;
    for (int k = 0; k < 25; k++) c += int'(v[k]);
    return c;
  endfunction

  function automatic void model_step(input logic [24:0] p);
    int nx [8];
    int win = -1;
    for (int i = 0; i < 8; i++) begin
      int d = popc(p & mw[i]);
      if (d > 0) begin
        nx[i] = mu[i] + 2 * d;
        if (nx[i] > 1023) nx[i] = 1023;
      end else nx[i] = mu[i] - (mu[i] >> 3);
      if (nx[i] >= 200 && win < 0) win = i;
    end
    for (int i = 0; i < 8; i++) mu[i] = (win >= 0) ? 0 : nx[i];
    if (win >= 0 && mc[win] < 255) mc[win]++;
  endfunction

  function automatic int model_best();
    int b = 0;
    for (int i = 1; i < 8; i++) if (mc[i] > mc[b]) b = i;
    return b;
  endfunction

  task automatic load_row(input int idx, input logic [24:0] row);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_row = row;
    mw[idx] = row;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // e1/e2: weight writes applied after update e?j (j=0 means none)
  task automatic run_win(input logic [24:0] p, input int wl, input string tag,
                         input int e1j, input int e1i, input logic [24:0] e1v,
                         input int e2j, input int e2i, input logic [24:0] e2v);
    int L = (wl == 0) ? 256 : wl;
    int exp_cls, lat = -1;
    for (int i = 0; i < 8; i++) begin mu[i] = 0; mc[i] = 0; end
    for (int s = 1; s <= L; s++) begin
      model_step(p);
      if (s == e1j) mw[e1i] = e1v;
      if (s == e2j) mw[e2i] = e2v;
    end
    exp_cls = model_best();
    @(negedge clk);
    start = 1'b1; pattern = p; win_len = 16'(wl);
    for (int j = 1; j <= L + 4; j++) begin
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      if (class_valid) begin lat = j; break; end
      if (j == e1j) begin wr_en = 1'b1; wr_idx = 3'(e1i); wr_row = e1v; end
      if (j == e2j) begin wr_en = 1'b1; wr_idx = 3'(e2i); wr_row = e2v; end
    end
    wr_en = 1'b0;
    check(lat == L + 1, {tag, " R2 latency"}, lat, L + 1);
    check(lat > 0 && int'(class_id) == exp_cls, {tag, " R8 class"}, int'(class_id), exp_cls);
    @(negedge clk);
    check(!class_valid, {tag, " R8 pulse width"}, int'(class_valid), 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) mw[i] = '0;
    repeat (3) @(negedge clk);
    check(!class_valid, "R1 reset valid", int'(class_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!class_valid, "R1 idle after reset", int'(class_valid), 0);

    // R9: corner pixel 24 matched by single weight bit of neuron 2
    load_row(2, 25'h1000000);
    run_win(25'h1000000, 256, "R9 R5 corner pixel", 0, 0, '0, 0, 0, '0);
    // R3: zero length selects 256
    run_win(25'h1000000, 0, "R3 default window", 0, 0, '0, 0, 0, '0);
    // R8 tie: window too short to fire -> all counts zero -> class 0
    run_win(25'h1000000, 50, "R8 zero tie", 0, 0, '0, 0, 0, '0);
    load_row(2, '0);

    // R9: row written for neuron 6 equals pattern
    load_row(6, 25'h0A5_5A5A);
    run_win(25'h0A5_5A5A, 40, "R9 row select", 0, 0, '0, 0, 0, '0);
    // R6: identical rows fire together, lowest index wins
    load_row(4, 25'h0A5_5A5A);
    load_row(1, 25'h0A5_5A5A);
    run_win(25'h0A5_5A5A, 64, "R6 simultaneous", 0, 0, '0, 0, 0, '0);
    for (int i = 0; i < 8; i++) load_row(i, '0);

    // R4 leak: drive 12 for 8 updates, silent 20, restored
    load_row(3, 25'h0000FFF);
    run_win('1, 32, "R4 leak", 8, 3, 25'h0, 28, 3, 25'h0000FFF);
    // R7: lone neuron fires 512 times
    load_row(3, '1);
    run_win('1, 2048, "R7 saturation", 0, 0, '0, 0, 0, '0);
    load_row(3, '0);

    // R10: restart mid window
    load_row(5, 25'h1F00000);
    load_row(0, 25'h000001F);
    @(negedge clk);
    start = 1'b1; pattern = 25'h000001F; win_len = 16'd200;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    run_win(25'h1F00000, 100, "R10 restart", 0, 0, '0, 0, 0, '0);

    // Random rows and images
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 8; i++) load_row(i, 25'($urandom) & 25'($urandom));
      run_win(25'($urandom), int'($urandom_range(1, 300)), $sformatf("R4 R5 R6 rand%0d", t),
              0, 0, '0, 0, 0, '0);
    end
    summary();
  end
endmodule